// File: doc/BRIEF.md
# Register-Cached Matrix Multiplier

This block multiplies two square matrices of unsigned integers, A and B, each N by N with 32-bit elements, and writes the N by N product C with 64-bit elements. A and B live in two separate memories outside the block, each with one registered read port. C goes to a third memory through a write port. Because there are three memories, the block can read operands and write results in the same cycle.

The block copies all of A (row by row) and all of B (column by column) into 2N² internal registers. One row of A and one column of B are fetched together, one element of each per cycle. N multipliers feed a balanced tree of N-1 adders, so the block can finish one full dot product per cycle. The first row of C is computed while the fetch is still running: C[0][j] is produced as soon as column j of B is complete. Once the fetch has finished, the block makes no more operand reads. The rest of C then comes out at one element per cycle, which gives about 2N²−N cycles in total instead of N³.

A one-cycle start pulse begins a run. A one-cycle done pulse ends it.

Top module: `mat_mult_regcache`

## Requirements
- R1: Cycle k is counted from the clock edge that accepts start, which is k=0. In cycles k=0..N²−1, op_rd_en is high. In cycle k, a_addr equals k, and b_addr equals (k mod N)·N + k/N. Both memories hold their matrix row-major: element [r][c] is at address r·N+c.
- R2: The memories return read data on the cycle after the address, and the block stores that data. Step k fetches A[k/N][k mod N] and B[k mod N][k/N].
- R3: Each C[i][j] written is the sum over m of A[i][m]·B[m][j]. Operands are unsigned, and the sum is taken modulo 2^64.
- R4: During one run, every C element is written exactly once. Writes go in row-major order, and c_addr = i·N+j.
- R5: The write of C[0][j] happens in cycle k=(j+1)·N+2. For N≥4, some of these writes fall in cycles where op_rd_en is still high.
- R6: The element with row-major index m ≥ N−1 is written in cycle k = N²−N+3+m. There is one write per cycle, with no gaps, up to m=N²−1.
- R7: op_rd_en stays low from cycle N² until the next accepted start.
- R8: done is high for exactly one cycle, k=2N²−N+3, which is the cycle after the final C write.
- R9: A start pulse while busy is high is ignored. It causes no extra reads and no change to the write sequence or its timing.
- R10: busy is high from cycle 0 through the final write cycle and low in the done cycle. After reset, busy, done, op_rd_en and c_wr_en are all low.
- R11: N must be a power of two from 2 to 16. The data widths are 32 and 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a run |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse after the final C write |
| op_rd_en | output | 1 | Read enable for both the A and B memories |
| a_addr | output | 2·log2(N) | Read address into the A memory |
| a_rd_data | input | 32 | A memory data, one cycle after the address |
| b_addr | output | 2·log2(N) | Read address into the B memory |
| b_rd_data | input | 32 | B memory data, one cycle after the address |
| c_wr_en | output | 1 | Write enable for the C memory |
| c_addr | output | 2·log2(N) | Write address into the C memory (i·N+j) |
| c_wr_data | output | 64 | Result element C[i][j] |

## Verification
Two functions of the block can fall in the same cycle: the operand fetch and the first-row result writes. With N=4, the C[0][0], C[0][1] and C[0][2] writes land in cycles 6, 10 and 14, while reads run through cycle 15. The bench checks op_rd_en, both addresses, c_wr_en, c_addr and the data in every cycle against cycle numbers it derives from the requirements. Any shift caused by the overlap therefore shows up as a timing or value mismatch. It repeats this for several data patterns, including an all-ones case that forces the sum to wrap, and for a run that has a start pulse injected mid-fetch.

// File: rtl/mmrc_pkg.sv
package mmrc_pkg;
  localparam int OP_W_DEF  = 32;
  localparam int RES_W_DEF = 64;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_FILL  = 2'd1,
    SEQ_SWEEP = 2'd2
  } seq_e;
endpackage

// File: rtl/mmrc_fetch.sv
module mmrc_fetch #(
  parameter int N = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 kick,
  output logic                 op_rd_en,
  output logic [2*$clog2(N)-1:0] a_addr,
  output logic [2*$clog2(N)-1:0] b_addr,
  output logic                 cap_en,
  output logic [$clog2(N)-1:0] cap_line,
  output logic [$clog2(N)-1:0] cap_k
);
  localparam int L  = $clog2(N);
  localparam int AW = 2 * L;
  localparam int NN = N * N;

  logic [AW-1:0] nxt;
  logic [AW-1:0] stp_q;
  logic          stp_vld;

  assign nxt = a_addr + AW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      op_rd_en <= 1'b0;
      a_addr   <= '0;
      b_addr   <= '0;
      stp_vld  <= 1'b0;
      stp_q    <= '0;
    end else begin
      stp_vld <= op_rd_en;
      stp_q   <= a_addr;
      if (kick) begin
        op_rd_en <= 1'b1;
        a_addr   <= '0;
        b_addr   <= '0;
      end else if (op_rd_en) begin
        if (a_addr == AW'(NN - 1)) begin
          op_rd_en <= 1'b0;
        end else begin
          a_addr <= nxt;
          b_addr <= {nxt[L-1:0], nxt[AW-1:L]};
        end
      end
    end
  end

  assign cap_en   = stp_vld;
  assign cap_line = stp_q[AW-1:L];
  assign cap_k    = stp_q[L-1:0];

  // R1
  rd_addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (op_rd_en && $past(op_rd_en)) |-> (a_addr == $past(a_addr) + AW'(1)));

  // R1
  rd_run_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(op_rd_en) |-> ($past(a_addr) == AW'(NN - 1)));
endmodule

// File: rtl/mmrc_opstore.sv
module mmrc_opstore #(
  parameter int N    = 4,
  parameter int OP_W = 32
) (
  input  logic                       clk,
  input  logic                       we,
  input  logic [$clog2(N)-1:0]       line,
  input  logic [$clog2(N)-1:0]       k,
  input  logic [OP_W-1:0]            a_wdata,
  input  logic [OP_W-1:0]            b_wdata,
  input  logic [$clog2(N)-1:0]       rd_row,
  input  logic [$clog2(N)-1:0]       rd_col,
  output logic [N-1:0][OP_W-1:0]     a_vec,
  output logic [N-1:0][OP_W-1:0]     b_vec
);
  // Row line of A and column line of B, element index k.
  logic [N-1:0][OP_W-1:0] a_q [N];
  logic [N-1:0][OP_W-1:0] b_q [N];

  always_ff @(posedge clk) begin
    if (we) begin
      a_q[line][k] <= a_wdata;
      b_q[line][k] <= b_wdata;
    end
  end

  assign a_vec = a_q[rd_row];
  assign b_vec = b_q[rd_col];
endmodule

// File: rtl/mmrc_dot.sv
module mmrc_dot #(
  parameter int N     = 4,
  parameter int OP_W  = 32,
  parameter int RES_W = 64
) (
  input  logic [N-1:0][OP_W-1:0] a_vec,
  input  logic [N-1:0][OP_W-1:0] b_vec,
  output logic [RES_W-1:0]       sum
);
  localparam int NODES = 2 * N - 1;

  // Heap-ordered tree: leaves hold products, inner nodes hold N-1 adders.
  logic [NODES-1:0][RES_W-1:0] node;

  for (genvar g = 0; g < N; g++) begin : g_mul
    assign node[N - 1 + g] = RES_W'(a_vec[g]) * RES_W'(b_vec[g]);
  end

  for (genvar t = 0; t < N - 1; t++) begin : g_add
    assign node[t] = node[2 * t + 1] + node[2 * t + 2];
  end

  assign sum = node[0];
endmodule

// File: rtl/mat_mult_regcache.sv
module mat_mult_regcache #(
  parameter int N     = 4,
  parameter int OP_W  = mmrc_pkg::OP_W_DEF,
  parameter int RES_W = mmrc_pkg::RES_W_DEF
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  output logic                   busy,
  output logic                   done,
  output logic                   op_rd_en,
  output logic [2*$clog2(N)-1:0] a_addr,
  input  logic [OP_W-1:0]        a_rd_data,
  output logic [2*$clog2(N)-1:0] b_addr,
  input  logic [OP_W-1:0]        b_rd_data,
  output logic                   c_wr_en,
  output logic [2*$clog2(N)-1:0] c_addr,
  output logic [RES_W-1:0]       c_wr_data
);
  import mmrc_pkg::*;

  localparam int L  = $clog2(N);
  localparam int AW = 2 * L;
  localparam int NN = N * N;

  logic                   kick;
  logic                   cap_en;
  logic [L-1:0]           cap_line;
  logic [L-1:0]           cap_k;
  logic [N-1:0][OP_W-1:0] a_vec;
  logic [N-1:0][OP_W-1:0] b_vec;
  logic [RES_W-1:0]       dot_sum;
  logic                   go;
  logic [L-1:0]           ci;
  logic [L-1:0]           cj;
  logic                   c_last;
  seq_e                   seq;

  assign kick = start && !busy;

  mmrc_fetch #(.N(N)) u_fetch (
    .clk      (clk),
    .rst      (rst),
    .kick     (kick),
    .op_rd_en (op_rd_en),
    .a_addr   (a_addr),
    .b_addr   (b_addr),
    .cap_en   (cap_en),
    .cap_line (cap_line),
    .cap_k    (cap_k)
  );

  mmrc_opstore #(.N(N), .OP_W(OP_W)) u_store (
    .clk     (clk),
    .we      (cap_en),
    .line    (cap_line),
    .k       (cap_k),
    .a_wdata (a_rd_data),
    .b_wdata (b_rd_data),
    .rd_row  (ci),
    .rd_col  (cj),
    .a_vec   (a_vec),
    .b_vec   (b_vec)
  );

  mmrc_dot #(.N(N), .OP_W(OP_W), .RES_W(RES_W)) u_dot (
    .a_vec (a_vec),
    .b_vec (b_vec),
    .sum   (dot_sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      go        <= 1'b0;
      ci        <= '0;
      cj        <= '0;
      seq       <= SEQ_IDLE;
      c_wr_en   <= 1'b0;
      c_last    <= 1'b0;
      c_addr    <= '0;
      c_wr_data <= '0;
    end else begin
      done      <= 1'b0;
      c_wr_en   <= go;
      c_addr    <= {ci, cj};
      c_wr_data <= dot_sum;
      c_last    <= go && (ci == L'(N - 1)) && (cj == L'(N - 1));
      if (kick) begin
        busy <= 1'b1;
        seq  <= SEQ_FILL;
      end
      if (c_wr_en && c_last) begin
        done <= 1'b1;
        busy <= 1'b0;
      end
      if (cap_en && (cap_k == L'(N - 1))) begin
        // column cap_line of B is now complete: row 0 entry can be formed
        go <= 1'b1;
        ci <= '0;
        cj <= cap_line;
        if (cap_line == L'(N - 1)) seq <= SEQ_SWEEP;
      end else if (go && (seq == SEQ_SWEEP)) begin
        if ((ci == L'(N - 1)) && (cj == L'(N - 1))) begin
          go  <= 1'b0;
          seq <= SEQ_IDLE;
        end else if (cj == L'(N - 1)) begin
          ci <= ci + L'(1);
          cj <= '0;
        end else begin
          cj <= cj + L'(1);
        end
      end else begin
        go <= 1'b0;
      end
    end
  end

  // Checker state: writes seen in the current run.
  logic [AW:0] wr_seen;
  always_ff @(posedge clk) begin
    if (rst || kick) wr_seen <= '0;
    else if (c_wr_en) wr_seen <= wr_seen + (AW + 1)'(1);
  end

  // R4
  wr_order_chk: assert property (@(posedge clk) disable iff (rst)
    c_wr_en |-> ({1'b0, c_addr} == wr_seen));

  // R6
  sweep_gapless_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(c_wr_en) && ($past(c_addr) >= AW'(N - 1)) && ($past(c_addr) != AW'(NN - 1)))
      |-> c_wr_en);

  // R7
  no_late_read_chk: assert property (@(posedge clk) disable iff (rst)
    (seq == SEQ_SWEEP) |-> !op_rd_en);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(c_wr_en) && ($past(c_addr) == AW'(NN - 1))));

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(op_rd_en) |-> $past(start && !busy));

  // R10
  busy_during_write_chk: assert property (@(posedge clk) disable iff (rst)
    (c_wr_en || op_rd_en) |-> busy);
endmodule

// File: tb/mat_mult_regcache_bench.sv
module mat_mult_regcache_bench;
  localparam int N  = 4;
  localparam int L  = $clog2(N);
  localparam int AW = 2 * L;
  localparam int NN = N * N;
  localparam int LAST_K = 2 * NN - N + 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          busy, done, op_rd_en, c_wr_en;
  logic [AW-1:0] a_addr, b_addr, c_addr;
  logic [31:0]   a_rd_data, b_rd_data;
  logic [63:0]   c_wr_data;

  logic [31:0] amem [NN];
  logic [31:0] bmem [NN];
  logic [63:0] cmem [NN];
  logic [63:0] expc [NN];
  int          wr_cnt;
  int          checks = 0;
  int          fails = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  mat_mult_regcache #(.N(N)) u_mat_mult_regcache (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .op_rd_en(op_rd_en), .a_addr(a_addr), .a_rd_data(a_rd_data),
    .b_addr(b_addr), .b_rd_data(b_rd_data),
    .c_wr_en(c_wr_en), .c_addr(c_addr), .c_wr_data(c_wr_data)
  );

  // Operand memories with one-cycle registered read; result memory.
  always @(posedge clk) begin
    if (op_rd_en) begin
      a_rd_data <= amem[a_addr];
      b_rd_data <= bmem[b_addr];
    end
    if (c_wr_en) begin
      cmem[c_addr] <= c_wr_data;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] gen(int pat, int sel, int r, int c);
    logic [31:0] x;
    x = 32'(r * N + c + 1) * 32'h9E3779B9 ^ 32'(pat * 7919 + sel * 104729);
    x = x ^ (x >> 15);
    x = x * 32'h85EBCA6B;
    x = x ^ (x >> 13);
    case (pat)
      0: return (sel == 0) ? 32'(r == c) : 32'(r * N + c + 1);
      2: return 32'hFFFF_FFFF;
      3: return (sel == 0) ? 32'h0 : x;
      default: return x;
    endcase
  endfunction

  // Expected write cycle -> row-major index, or -1 (R5, R6).
  function automatic int wr_index(int k);
    for (int m = 0; m < NN; m++) begin
      int kk;
      kk = (m < N) ? (m + 1) * N + 2 : NN - N + 3 + m;
      if (kk == k) return m;
    end
    return -1;
  endfunction

  task automatic run_case(input int pat, input bit poke);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        amem[r * N + c] = gen(pat, 0, r, c);
        bmem[r * N + c] = gen(pat, 1, r, c);
      end
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        logic [63:0] acc;
        acc = 64'd0;
        for (int m = 0; m < N; m++)
          acc = acc + 64'(amem[i * N + m]) * 64'(bmem[m * N + j]);
        expc[i * N + j] = acc;
        cmem[i * N + j] = 64'hDEAD_BEEF_DEAD_BEEF;
      end
    wr_cnt = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int k = 0; k <= LAST_K + 2; k++) begin
      int m;
      // R1 / R7: read enable window and address order
      chk(op_rd_en == (k < NN), (k < NN) ? "R1" : "R7", "op_rd_en", 64'(op_rd_en), 64'(k < NN));
      if (k < NN && op_rd_en) begin
        chk(int'(a_addr) == k, "R1", "a_addr", 64'(a_addr), 64'(k));
        chk(int'(b_addr) == (k % N) * N + k / N, "R2", "b_addr", 64'(b_addr),
            64'((k % N) * N + k / N));
      end
      m = wr_index(k);
      chk(c_wr_en == (m >= 0), (m >= 0 && m < N) ? "R5" : "R6", "c_wr_en",
          64'(c_wr_en), 64'(m >= 0));
      if (m >= 0 && c_wr_en) begin
        chk(int'(c_addr) == m, "R4", "c_addr", 64'(c_addr), 64'(m));
        chk(c_wr_data == expc[m], "R3", "c_wr_data", c_wr_data, expc[m]);
        // R5: the first row overlaps the fetch when the column is ready early
        if (m < N - 1) chk(op_rd_en, "R5", "overlap read", 64'(op_rd_en), 64'd1);
      end
      chk(done == (k == LAST_K + 1), "R8", "done", 64'(done), 64'(k == LAST_K + 1));
      chk(busy == (k <= LAST_K), "R10", "busy", 64'(busy), 64'(k <= LAST_K));
      if (poke && k == 5) start = 1'b1;  // R9: start while busy
      if (poke && k == 6) start = 1'b0;
      @(negedge clk);
    end
    chk(wr_cnt == NN, "R4", "write count", 64'(wr_cnt), 64'(NN));
    for (int i = 0; i < NN; i++)
      chk(cmem[i] == expc[i], "R3", "stored C", cmem[i], expc[i]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk(!busy && !done && !op_rd_en && !c_wr_en, "R10", "reset outputs",
        {60'd0, busy, done, op_rd_en, c_wr_en}, 64'd0);
    run_case(0, 1'b0);  // identity times counting: R3
    run_case(1, 1'b0);  // mixed values
    run_case(2, 1'b0);  // all ones, sum wraps modulo 2^64: R3, R11
    run_case(3, 1'b0);  // zero A
    run_case(4, 1'b1);  // start pulse mid-run ignored: R9
    run_case(5, 1'b0);  // back-to-back run after the ignored start
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule